// File: doc/BRIEF.md
# SPI Command Queue Sequencer

This block walks a 16-entry command list for a queued SPI master. It does not move serial data. For each step it hands the index of the next command to a separate shift engine through a start/done handshake. It keeps a record of the last command that finished, and it decides where to go next. It holds four 4-bit pointers:

- **Start pointer**: set by software; the queue begins here.
- **Last pointer**: set by software; marks the end of the list.
- **Completed pointer**: the index of the command that finished last.
- **Working pointer**: the index of the next command to run.

Software programs the start pointer, the last pointer and a wraparound enable through a small write-only register port. It then raises a run input. The sequencer runs commands in turn. When the completed index equals the last pointer, it raises a sticky finished flag. It then halts, or it loops back to the start pointer if wraparound is on.

A start-pointer write that lands while a transfer is outstanding is held back. It is applied only when that transfer reports done. Dropping the run input lets the current transfer finish and then halts the sequencer.

Register map (2-bit address, data on the low bits):

| Address | Name | Meaning of a write |
|---|---|---|
| 0 | start pointer | loads the start pointer |
| 1 | last pointer | loads the last pointer |
| 2 | control | bit 0 is the wraparound enable |
| 3 | status | writing 1 to bit 0 clears the finished flag |

Top module: `spi_cmdq_seq`

## Requirements
- R1: After reset, the outputs are quiet and the pointers are cleared. `busy`, `xfer_start` and `done_flag` are 0. `work_ptr` and `cpt_ptr` are 0. The start pointer, the last pointer and the wraparound enable are 0.
- R2: A 0-to-1 edge on `run_en` while idle loads the working pointer from the start pointer. The first `xfer_start` then carries that index on `xfer_idx`.
- R3: On each `xfer_done`, the pointers move in a fixed order. `cpt_ptr` takes the index of the command just finished. The working pointer then advances by one, wrapping from 15 to 0.
- R4: When a finished command's index equals the last pointer, `done_flag` is set. With wraparound off, the sequencer halts: `busy` falls and no further `xfer_start` appears.
- R5: With wraparound on (control bit 0 = 1) and `run_en` high, an end match does not halt the sequencer. The next command is taken from the start pointer.
- R6: `done_flag` stays set until software writes 1 to status bit 0. Writing 0 to that bit leaves the flag unchanged.
- R7: While idle, a write to the start pointer moves `work_ptr` to the written value in the next cycle.
- R8: A start-pointer write made while a transfer is outstanding leaves that transfer unchanged. The following command is taken from the new value.
- R9: With the start and last pointers both 0 and wraparound off, one run produces exactly one transfer, at index 0.
- R10: Dropping `run_en` during a transfer lets that transfer finish and then halts the sequencer. `done_flag` is not set unless the finished index matched the last pointer.
- R11: `busy` rises in the cycle after the `run_en` edge and stays high until the halt. `xfer_start` is a single-cycle pulse given only while busy. No new `xfer_start` appears until the outstanding transfer reports done.
- R12: A write to the last pointer takes effect on the next end compare, even while the sequencer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 start, 1 last, 2 control, 3 status) |
| reg_wdata | input | 4 | Register write data |
| run_en | input | 1 | Queue enable; a 0-to-1 edge starts a run, a low level halts it after the current transfer |
| xfer_done | input | 1 | Shift engine reports that the current command has finished |
| xfer_start | output | 1 | One-cycle request to the shift engine to run the command at `xfer_idx` |
| xfer_idx | output | 4 | Index of the command to run |
| work_ptr | output | 4 | Working pointer |
| cpt_ptr | output | 4 | Completed pointer |
| done_flag | output | 1 | Sticky finished flag |
| busy | output | 1 | High while the queue is running |

## Verification
A wrong working pointer shows up at the very next `xfer_start`: the `xfer_idx` there will not match the index the scoreboard expects. The same fault also shows one done later on `cpt_ptr`.

A lost or misapplied deferred reload breaks the index stream at the command after the write, not at the write itself.

A bad end compare has two visible effects. It changes how many transfers occur before `busy` falls, and it changes whether `done_flag` is set. Both are visible within a cycle of the done that should have ended the run.

// File: rtl/spi_cmdq_pkg.sv
package spi_cmdq_pkg;

    localparam int unsigned REG_AW = 2;

    localparam logic [REG_AW-1:0] A_NEWQ = 2'd0;
    localparam logic [REG_AW-1:0] A_ENDQ = 2'd1;
    localparam logic [REG_AW-1:0] A_CTRL = 2'd2;
    localparam logic [REG_AW-1:0] A_STAT = 2'd3;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/cmdq_cfg_regs.sv
module cmdq_cfg_regs
    import spi_cmdq_pkg::*;
#(
    parameter int unsigned PTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [PTR_W-1:0]  wdata,
    output logic [PTR_W-1:0]  new_ptr,
    output logic [PTR_W-1:0]  end_ptr,
    output logic              wrap_en,
    output logic              new_wr,
    output logic              flag_clr
);

    typedef struct packed {
        logic [PTR_W-1:0] newq;
        logic [PTR_W-1:0] endq;
        logic             wrap;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_hi;

    assign unused_hi = ^wdata[PTR_W-1:1];

    always_comb begin
        cfg_d    = cfg_q;
        new_wr   = 1'b0;
        flag_clr = 1'b0;
        if (wr) begin
            unique case (addr)
                A_NEWQ: begin
                    cfg_d.newq = wdata;
                    new_wr     = 1'b1;
                end
                A_ENDQ: cfg_d.endq = wdata;
                A_CTRL: cfg_d.wrap = wdata[0];
                A_STAT: flag_clr   = wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign new_ptr = cfg_q.newq;
    assign end_ptr = cfg_q.endq;
    assign wrap_en = cfg_q.wrap;

endmodule

// File: rtl/cmdq_seq_fsm.sv
module cmdq_seq_fsm
    import spi_cmdq_pkg::*;
#(
    parameter int unsigned PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [PTR_W-1:0] new_ptr,
    input  logic [PTR_W-1:0] end_ptr,
    input  logic             wrap_en,
    input  logic             new_wr,
    input  logic [PTR_W-1:0] new_wdata,
    input  logic             flag_clr,
    input  logic             xfer_done,
    output logic             xfer_start,
    output logic [PTR_W-1:0] xfer_idx,
    output logic [PTR_W-1:0] work_ptr,
    output logic [PTR_W-1:0] cpt_ptr,
    output logic             done_flag,
    output logic             busy,
    output logic             waiting
);

    typedef struct packed {
        seq_state_e       state;
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] cpt;
        logic             flag;
        logic             pend;
        logic             run_q;
    } seq_t;

    seq_t s_d, s_q;

    logic             reload_hit;
    logic [PTR_W-1:0] reload_val;
    logic [PTR_W-1:0] wptr_inc;
    logic             end_hit;
    logic             run_rise;

    // A write in the same cycle as the done takes priority over the stored value.
    assign reload_hit = s_q.pend | new_wr;
    assign reload_val = new_wr ? new_wdata : new_ptr;
    assign wptr_inc   = s_q.wptr + PTR_W'(1);
    assign end_hit    = (s_q.wptr == end_ptr);
    assign run_rise   = run_en & ~s_q.run_q;

    always_comb begin
        s_d       = s_q;
        s_d.run_q = run_en;

        // Clear first so that a set in the same cycle wins.
        if (flag_clr) begin
            s_d.flag = 1'b0;
        end

        unique case (s_q.state)
            SQ_IDLE: begin
                s_d.pend = 1'b0;
                if (new_wr) begin
                    s_d.wptr = new_wdata;
                end
                if (run_rise) begin
                    s_d.wptr  = reload_val;
                    s_d.state = SQ_ISSUE;
                end
            end

            SQ_ISSUE: begin
                if (new_wr) begin
                    s_d.pend = 1'b1;
                end
                s_d.state = SQ_WAIT;
            end

            SQ_WAIT: begin
                if (new_wr) begin
                    s_d.pend = 1'b1;
                end
                if (xfer_done) begin
                    s_d.cpt  = s_q.wptr;
                    s_d.pend = 1'b0;
                    if (end_hit) begin
                        s_d.flag = 1'b1;
                    end
                    if (!run_en || (end_hit && !wrap_en)) begin
                        s_d.state = SQ_IDLE;
                        s_d.wptr  = reload_hit ? reload_val : wptr_inc;
                    end else if (end_hit) begin
                        s_d.state = SQ_ISSUE;
                        s_d.wptr  = reload_val;
                    end else begin
                        s_d.state = SQ_ISSUE;
                        s_d.wptr  = reload_hit ? reload_val : wptr_inc;
                    end
                end
            end

            default: begin
                s_d.state = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: SQ_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign xfer_start = (s_q.state == SQ_ISSUE);
    assign xfer_idx   = s_q.wptr;
    assign work_ptr   = s_q.wptr;
    assign cpt_ptr    = s_q.cpt;
    assign done_flag  = s_q.flag;
    assign busy       = (s_q.state != SQ_IDLE);
    assign waiting    = (s_q.state == SQ_WAIT);

endmodule

// File: rtl/spi_cmdq_seq.sv
module spi_cmdq_seq
    import spi_cmdq_pkg::*;
#(
    parameter int unsigned PTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [PTR_W-1:0]  reg_wdata,
    input  logic              run_en,
    input  logic              xfer_done,
    output logic              xfer_start,
    output logic [PTR_W-1:0]  xfer_idx,
    output logic [PTR_W-1:0]  work_ptr,
    output logic [PTR_W-1:0]  cpt_ptr,
    output logic              done_flag,
    output logic              busy
);

    logic [PTR_W-1:0] new_ptr;
    logic [PTR_W-1:0] end_ptr;
    logic             wrap_en;
    logic             new_wr;
    logic             flag_clr;
    logic             waiting;

    cmdq_cfg_regs #(.PTR_W(PTR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .new_ptr  (new_ptr),
        .end_ptr  (end_ptr),
        .wrap_en  (wrap_en),
        .new_wr   (new_wr),
        .flag_clr (flag_clr)
    );

    cmdq_seq_fsm #(.PTR_W(PTR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .new_ptr    (new_ptr),
        .end_ptr    (end_ptr),
        .wrap_en    (wrap_en),
        .new_wr     (new_wr),
        .new_wdata  (reg_wdata),
        .flag_clr   (flag_clr),
        .xfer_done  (xfer_done),
        .xfer_start (xfer_start),
        .xfer_idx   (xfer_idx),
        .work_ptr   (work_ptr),
        .cpt_ptr    (cpt_ptr),
        .done_flag  (done_flag),
        .busy       (busy),
        .waiting    (waiting)
    );

endmodule

// File: rtl/spi_cmdq_seq_chk.sv
module spi_cmdq_seq_chk #(
    parameter int unsigned PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             xfer_done,
    input logic             xfer_start,
    input logic [PTR_W-1:0] work_ptr,
    input logic [PTR_W-1:0] cpt_ptr,
    input logic             done_flag,
    input logic             busy,
    input logic             waiting,
    input logic [PTR_W-1:0] new_ptr,
    input logic [PTR_W-1:0] end_ptr,
    input logic             wrap_en,
    input logic             new_wr
);

    assert_start_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> busy);

    assert_single_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> (!xfer_start && waiting));

    assert_cpt_tracks_finished_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && xfer_done) |=> (cpt_ptr == $past(work_ptr)));

    assert_flag_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && xfer_done && work_ptr == end_ptr) |=> done_flag);

    assert_halt_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && xfer_done && work_ptr == end_ptr && !wrap_en) |=> !busy);

    assert_wrap_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && xfer_done && work_ptr == end_ptr && wrap_en && run_en && !new_wr)
        |=> (busy && work_ptr == $past(new_ptr)));

    assert_halt_on_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && xfer_done && !run_en) |=> !busy);

endmodule

bind spi_cmdq_seq spi_cmdq_seq_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .xfer_done  (xfer_done),
    .xfer_start (xfer_start),
    .work_ptr   (work_ptr),
    .cpt_ptr    (cpt_ptr),
    .done_flag  (done_flag),
    .busy       (busy),
    .waiting    (waiting),
    .new_ptr    (new_ptr),
    .end_ptr    (end_ptr),
    .wrap_en    (wrap_en),
    .new_wr     (new_wr)
);

// File: tb/spi_cmdq_seq_test.sv
`timescale 1ns/1ps
module spi_cmdq_seq_test;

    localparam int PW       = 4;
    localparam int DONE_DLY = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [PW-1:0] reg_wdata = '0;
    logic          run_en = 1'b0;
    logic          xfer_done = 1'b0;
    logic          xfer_start;
    logic [PW-1:0] xfer_idx;
    logic [PW-1:0] work_ptr;
    logic [PW-1:0] cpt_ptr;
    logic          done_flag;
    logic          busy;

    int checks = 0;
    int errors = 0;
    int start_cnt = 0;
    int exp_q[$];
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spi_cmdq_seq #(.PTR_W(PW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .run_en     (run_en),
        .xfer_done  (xfer_done),
        .xfer_start (xfer_start),
        .xfer_idx   (xfer_idx),
        .work_ptr   (work_ptr),
        .cpt_ptr    (cpt_ptr),
        .done_flag  (done_flag),
        .busy       (busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Shift engine model: answers each start with a done DONE_DLY cycles later.
    initial begin
        forever begin
            @(negedge clk);
            xfer_done = 1'b0;
            if (xfer_start) begin
                repeat (DONE_DLY - 1) @(negedge clk);
                xfer_done = 1'b1;
            end
        end
    end

    // Scoreboard monitor: every start must match the next expected index.
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_start) begin
                start_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4/R11", "unexpected xfer_start idx", int'(xfer_idx), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(xfer_idx) == e, "R2/R3/R5/R8", "xfer_idx", int'(xfer_idx), e);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        check(1'b0, "WATCHDOG", "run did not end", 0, 1);
        summary();
    end

    task automatic reg_write(input logic [1:0] a, input int v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = PW'(v);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic push(input int v);
        exp_q.push_back(v);
    endtask

    // stop_after = 0: run until the sequencer halts by itself.
    task automatic run_queue(input int stop_after);
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R11", "busy after run edge", int'(busy), 1);
        if (stop_after > 0) begin
            while (start_cnt < stop_after) @(negedge clk);
            @(negedge clk);
            run_en = 1'b0;
        end
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        check(busy == 1'b0, "R4/R10", "busy after halt", int'(busy), 0);
        run_en = 1'b0;
        repeat (3 * DONE_DLY) @(negedge clk);
        check(exp_q.size() == 0, "R4/R10", "expected starts left over", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(busy == 0, "R1", "busy", int'(busy), 0);
        check(xfer_start == 0, "R1", "xfer_start", int'(xfer_start), 0);
        check(done_flag == 0, "R1", "done_flag", int'(done_flag), 0);
        check(work_ptr == 0, "R1", "work_ptr", int'(work_ptr), 0);
        check(cpt_ptr == 0, "R1", "cpt_ptr", int'(cpt_ptr), 0);

        // R9: default pointers give exactly one transfer at index 0
        start_cnt = 0;
        push(0);
        run_queue(0);
        check(start_cnt == 1, "R9", "transfer count", start_cnt, 1);
        check(done_flag == 1, "R9", "done_flag", int'(done_flag), 1);
        check(cpt_ptr == 0, "R9", "cpt_ptr", int'(cpt_ptr), 0);
        check(work_ptr == 1, "R3", "work_ptr after single", int'(work_ptr), 1);

        // R6 sticky flag, write-one-to-clear
        reg_write(2'd3, 0);
        @(negedge clk);
        check(done_flag == 1, "R6", "flag after writing 0", int'(done_flag), 1);
        reg_write(2'd3, 1);
        @(negedge clk);
        check(done_flag == 0, "R6", "flag after writing 1", int'(done_flag), 0);

        // R2/R3/R4 plain run 2..4
        reg_write(2'd0, 2);
        reg_write(2'd1, 4);
        start_cnt = 0;
        push(2); push(3); push(4);
        run_queue(0);
        check(start_cnt == 3, "R4", "transfer count", start_cnt, 3);
        check(cpt_ptr == 4, "R3", "cpt_ptr", int'(cpt_ptr), 4);
        check(work_ptr == 5, "R3", "work_ptr", int'(work_ptr), 5);
        check(done_flag == 1, "R4", "done_flag", int'(done_flag), 1);
        reg_write(2'd3, 1);

        // R3 wrap of the working pointer from 15 to 0
        reg_write(2'd0, 14);
        reg_write(2'd1, 1);
        start_cnt = 0;
        push(14); push(15); push(0); push(1);
        run_queue(0);
        check(cpt_ptr == 1, "R3", "cpt_ptr after 15->0", int'(cpt_ptr), 1);
        check(work_ptr == 2, "R3", "work_ptr after 15->0", int'(work_ptr), 2);
        reg_write(2'd3, 1);

        // R7 idle write moves the working pointer at once
        reg_write(2'd0, 11);
        check(work_ptr == 11, "R7", "work_ptr after idle write", int'(work_ptr), 11);

        // R8/R12 deferred reload and live end change
        reg_write(2'd0, 0);
        reg_write(2'd1, 9);
        start_cnt = 0;
        push(0); push(7); push(8);
        fork
            run_queue(0);
            begin
                while (start_cnt < 1) @(negedge clk);
                check(work_ptr == 0, "R8", "work_ptr before reload", int'(work_ptr), 0);
                reg_write(2'd0, 7);
                reg_write(2'd1, 8);
            end
        join
        check(cpt_ptr == 8, "R12", "cpt_ptr at new end", int'(cpt_ptr), 8);
        check(work_ptr == 9, "R8", "work_ptr", int'(work_ptr), 9);
        check(done_flag == 1, "R12", "done_flag", int'(done_flag), 1);
        reg_write(2'd3, 1);

        // R5/R10 wraparound loop halted by dropping run_en
        reg_write(2'd0, 5);
        reg_write(2'd1, 6);
        reg_write(2'd2, 1);
        start_cnt = 0;
        push(5); push(6); push(5); push(6); push(5);
        run_queue(5);
        check(start_cnt == 5, "R5", "transfer count", start_cnt, 5);
        check(cpt_ptr == 5, "R10", "cpt_ptr", int'(cpt_ptr), 5);
        check(work_ptr == 6, "R10", "work_ptr", int'(work_ptr), 6);
        check(done_flag == 1, "R5", "done_flag", int'(done_flag), 1);
        reg_write(2'd3, 1);
        reg_write(2'd2, 0);

        // R10 halt without an end match leaves the flag clear
        reg_write(2'd0, 0);
        reg_write(2'd1, 15);
        start_cnt = 0;
        push(0); push(1);
        run_queue(2);
        check(start_cnt == 2, "R10", "transfer count", start_cnt, 2);
        check(done_flag == 0, "R10", "done_flag", int'(done_flag), 0);
        check(cpt_ptr == 1, "R10", "cpt_ptr", int'(cpt_ptr), 1);

        summary();
    end

endmodule